// File: doc/BRIEF.md
# Coalescing interrupt source bank

This block holds a bank of interrupt sources. Each source keeps a two-bit coalescing state: a "sent" flag (P) and a "fired again while sent" flag (Q). The block forwards an interrupt at most once until software signals end-of-interrupt. A source fires on a rising edge of its input line, or when software stores to that source's trigger page. Software reads or rewrites a source's state with 8-byte loads at fixed offsets in that source's management page. Each of these loads returns the state the source had before the access and updates it in the same cycle.

The address space gives each source a region of `1 << SHIFT` bytes. An odd `SHIFT` (13 or 17) selects split pages: the lower half of the region is the trigger page and the upper half is the management page. An even `SHIFT` (12 or 16) selects one shared page that does both jobs. Sources marked in `LEVEL_MASK` are level-sensitive. They also report whether their line is high, and they fire again if the line is still high after an end-of-interrupt that drops P. Notifications leave on a valid/ready port that carries the source number. Stores carry no data, because the value stored never matters.

Top module: `esb_source_bank`

## Requirements
- R1: After reset every source is in state 00 (P=0, Q=0) and `ntf_valid` is low. State bits are P in bit 1 and Q in bit 0: 00 idle, 10 sent, 11 sent and fired again, 01 masked.
- R2: A trigger moves 00 to 10 and emits one notification, moves 10 or 11 to 11 without one, and leaves 01 as it is.
- R3: A load at management offset 0x000 is an end-of-interrupt. From 11 it moves to 10 and emits a notification. From 00 or 10 it moves to 00. From 01 it leaves the state unchanged.
- R4: A load at management offset 0x800 does not change the state. Every accepted load raises `rsp_valid` on the next cycle. Its `rsp_data` holds the previous state in bits [1:0] and the line-asserted flag in bit 2 (always 0 for edge sources), with all other bits zero. Stores produce no response.
- R5: Loads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11 respectively, and emit no notification.
- R6: A store at management offset 0x400 is an end-of-interrupt (as in R3) when `STORE_EOI` is 1. It is ignored when `STORE_EOI` is 0.
- R7: Source s owns the region starting at `s << SHIFT`. With odd `SHIFT`, the management page starts at `(s << SHIFT) + (1 << (SHIFT-1))`. A store anywhere in the trigger page triggers, and loads from the trigger page are ignored. Stores to management offsets other than 0x400 do nothing. With even `SHIFT` there is one page, and any store to it other than at offset 0x400 triggers.
- R8: A rising edge on `irq_line[s]` triggers source s once. Holding the line high does not trigger it again.
- R9: A level-sensitive source reports its registered line level as bit 2 of load data. If an end-of-interrupt takes it from 10 to 00 while the line is high, it triggers again in the same cycle: it ends in 10 and emits a notification.
- R10: Misaligned accesses (address bits [2:0] not zero) are ignored, as are accesses at undefined offsets and accesses to source numbers of `NUM_SRC` or above. An ignored load returns all ones.
- R11: `ntf_src` offers the lowest-numbered pending source. While `ntf_valid` is high and `ntf_ready` is low, `ntf_src` stays stable. Each handshake retires exactly one notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | NUM_SRC | Per-source interrupt input lines |
| req_valid | input | 1 | Access request strobe, one access per cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | SHIFT+IDX_W+1 | Byte address of the 8-byte access |
| rsp_valid | output | 1 | Load data valid, one cycle after the load |
| rsp_data | output | 64 | Load data |
| ntf_valid | output | 1 | A notification is offered |
| ntf_ready | input | 1 | Consumer accepts the offered notification |
| ntf_src | output | IDX_W | Source number of the offered notification |

## Verification
The properties assume that the access port sees at most one request per cycle. They also assume a consumer that may stall notifications for any length of time, and input lines that change only between clock edges. The bench drives every request and line change on the falling edge and holds `ntf_ready` low while it inspects a notification. It then drains the queue with `ntf_ready` high before the next case, so no stale notification can be mistaken for a new one. Line stimulus never coincides with an access to the same source, so each observed transition has exactly one cause.

// File: rtl/esb_pkg.sv
package esb_pkg;

    typedef enum logic [1:0] {
        PQ_IDLE   = 2'b00,
        PQ_MASKED = 2'b01,
        PQ_SENT   = 2'b10,
        PQ_AGAIN  = 2'b11
    } pq_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GET,
        OP_EOI,
        OP_SET,
        OP_TRIG
    } op_e;

    typedef struct packed {
        pq_e  st;
        logic fire;
    } step_t;

    localparam logic [11:0] OFS_EOI_LD = 12'h000;
    localparam logic [11:0] OFS_EOI_ST = 12'h400;
    localparam logic [11:0] OFS_GET    = 12'h800;

    function automatic step_t on_trigger(pq_e s);
        step_t r;
        r.fire = 1'b0;
        case (s)
            PQ_IDLE:   begin r.st = PQ_SENT; r.fire = 1'b1; end
            PQ_MASKED: r.st = PQ_MASKED;
            default:   r.st = PQ_AGAIN;
        endcase
        return r;
    endfunction

    function automatic step_t on_eoi(pq_e s);
        step_t r;
        r.fire = 1'b0;
        case (s)
            PQ_MASKED: r.st = PQ_MASKED;
            PQ_AGAIN:  begin r.st = PQ_SENT; r.fire = 1'b1; end
            default:   r.st = PQ_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/esb_decode.sv
module esb_decode
    import esb_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int SHIFT     = 13,
    parameter bit STORE_EOI = 1'b1,
    parameter int IDX_W     = 3,
    parameter int ADDR_W    = 17
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output op_e               op,
    output pq_e               set_val,
    output logic [IDX_W-1:0]  src_idx
);

    localparam bit TWO_PAGE = (SHIFT % 2) == 1;
    localparam int MGMT_W   = TWO_PAGE ? SHIFT - 1 : SHIFT;

    logic [IDX_W:0]    src_f;
    logic [MGMT_W-1:0] off;
    logic [11:0]       lo;
    logic              hi_zero;
    logic              mgmt_pg;
    logic              trig_pg;
    logic              in_range;
    logic              aligned;

    assign src_f    = req_addr[ADDR_W-1:SHIFT];
    assign off      = req_addr[MGMT_W-1:0];
    assign lo       = off[11:0];
    assign hi_zero  = (off >> 12) == '0;
    assign in_range = 32'(src_f) < NUM_SRC;
    assign aligned  = off[2:0] == 3'b000;
    assign src_idx  = src_f[IDX_W-1:0];

    generate
        if (TWO_PAGE) begin : g_split
            assign mgmt_pg = req_addr[SHIFT-1];
            assign trig_pg = ~req_addr[SHIFT-1];
        end else begin : g_shared
            assign mgmt_pg = 1'b1;
            assign trig_pg = 1'b1;
        end
    endgenerate

    always_comb begin
        op      = OP_NONE;
        set_val = PQ_IDLE;
        if (!req_write) begin
            if (mgmt_pg && hi_zero) begin
                if (lo == OFS_EOI_LD) begin
                    op = OP_EOI;
                end else if (lo == OFS_GET) begin
                    op = OP_GET;
                end else if (lo[11:10] == 2'b11 && lo[7:0] == 8'h00) begin
                    op      = OP_SET;
                    set_val = pq_e'(lo[9:8]);
                end
            end
        end else begin
            if (mgmt_pg && hi_zero && lo == OFS_EOI_ST) begin
                op = STORE_EOI ? OP_EOI : OP_NONE;
            end else if (trig_pg) begin
                op = OP_TRIG;
            end
        end
    end

    assign hit = req_valid && in_range && aligned && (op != OP_NONE);

endmodule

// File: rtl/esb_cell.sv
module esb_cell
    import esb_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic op_hit,
    input  op_e  op,
    input  pq_e  set_val,
    input  logic line_in,
    output pq_e  state,
    output logic asserted,
    output logic fire
);

    pq_e   st_q;
    pq_e   st_d;
    pq_e   mid;
    logic  line_q;
    logic  rise;
    logic  did_eoi;
    logic  retrig;
    logic  trig;
    logic  fire_op;
    step_t s_op;
    step_t s_tr;

    assign rise = line_in & ~line_q;

    always_comb begin
        mid     = st_q;
        fire_op = 1'b0;
        did_eoi = 1'b0;
        s_op    = on_eoi(st_q);
        if (op_hit) begin
            case (op)
                OP_EOI: begin
                    mid     = s_op.st;
                    fire_op = s_op.fire;
                    did_eoi = 1'b1;
                end
                OP_SET:  mid = set_val;
                default: mid = st_q;
            endcase
        end
        retrig = IS_LEVEL && did_eoi && st_q[1] && !mid[1] && line_q;
        trig   = rise || (op_hit && op == OP_TRIG) || retrig;
        s_tr   = on_trigger(mid);
        st_d   = trig ? s_tr.st : mid;
        fire   = fire_op || (trig && s_tr.fire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PQ_IDLE;
            line_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            line_q <= line_in;
        end
    end

    assign state    = st_q;
    assign asserted = IS_LEVEL ? line_q : 1'b0;

    AST_FIRE_LEAVES_SENT: assert property (@(posedge clk) disable iff (rst)
        fire |=> st_q[1]);  // R2

    AST_MASKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == PQ_MASKED && !op_hit) |=> st_q == PQ_MASKED);  // R2

    AST_LEVEL_REFIRE: assert property (@(posedge clk) disable iff (rst)
        (IS_LEVEL && op_hit && op == OP_EOI && st_q == PQ_SENT && line_q)
        |=> st_q == PQ_SENT);  // R9

endmodule

// File: rtl/esb_notify.sv
module esb_notify #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] fire,
    input  logic               ready,
    output logic               valid,
    output logic [IDX_W-1:0]   src
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr;
    logic [IDX_W-1:0]   pick;
    logic [IDX_W-1:0]   sel_q;
    logic               locked_q;
    logic               take;

    always_comb begin
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = IDX_W'(i);
        end
    end

    assign src   = locked_q ? sel_q : pick;
    assign valid = |pend_q;
    assign take  = valid && ready;
    assign clr   = take ? (NUM_SRC'(1) << src) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            sel_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            pend_q   <= (pend_q & ~clr) | fire;
            sel_q    <= src;
            locked_q <= valid && !ready;
        end
    end

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(src)));  // R11

endmodule

// File: rtl/esb_source_bank.sv
module esb_source_bank
    import esb_pkg::*;
#(
    parameter int                  NUM_SRC    = 8,
    parameter int                  SHIFT      = 13,
    parameter bit                  STORE_EOI  = 1'b1,
    parameter logic [NUM_SRC-1:0]  LEVEL_MASK = 8'hC0,
    localparam int                 IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int                 ADDR_W     = SHIFT + IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_line,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic [63:0]        rsp_data,
    output logic               ntf_valid,
    input  logic               ntf_ready,
    output logic [IDX_W-1:0]   ntf_src
);

    logic               hit;
    op_e                op;
    pq_e                set_val;
    logic [IDX_W-1:0]   src_idx;
    pq_e                cell_state [NUM_SRC];
    logic [NUM_SRC-1:0] cell_asserted;
    logic [NUM_SRC-1:0] cell_fire;
    logic               rsp_valid_q;
    logic [63:0]        rsp_data_q;

    esb_decode #(
        .NUM_SRC   (NUM_SRC),
        .SHIFT     (SHIFT),
        .STORE_EOI (STORE_EOI),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .hit       (hit),
        .op        (op),
        .set_val   (set_val),
        .src_idx   (src_idx)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            esb_cell #(
                .IS_LEVEL (LEVEL_MASK[i])
            ) u_cell (
                .clk      (clk),
                .rst      (rst),
                .op_hit   (hit && (src_idx == IDX_W'(i))),
                .op       (op),
                .set_val  (set_val),
                .line_in  (irq_line[i]),
                .state    (cell_state[i]),
                .asserted (cell_asserted[i]),
                .fire     (cell_fire[i])
            );
        end
    endgenerate

    esb_notify #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_notify (
        .clk   (clk),
        .rst   (rst),
        .fire  (cell_fire),
        .ready (ntf_ready),
        .valid (ntf_valid),
        .src   (ntf_src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_data_q <= (hit) ? {61'b0, cell_asserted[src_idx], cell_state[src_idx]}
                                    : '1;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    AST_LOAD_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);  // R4

    AST_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid);  // R4

    AST_FAR_SOURCE_ONES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && 32'(req_addr[ADDR_W-1:SHIFT]) >= NUM_SRC)
        |=> rsp_data == '1);  // R10

endmodule

// File: tb/esb_source_bank_test.sv
module esb_source_bank_test;

    localparam int N   = 8;
    localparam int AW0 = 17;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq;
    logic [N-1:0]  irq1;
    logic          v0, v1, wr;
    logic [AW0-1:0] addr;
    logic          rv0, rv1;
    logic [63:0]   rd0, rd1;
    logic          nv0, nv1, nr0, nr1;
    logic [2:0]    ns0, ns1;
    logic [63:0]   d;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    always #10 clk = ~clk;

    esb_source_bank #(
        .NUM_SRC (N), .SHIFT (13), .STORE_EOI (1'b1), .LEVEL_MASK (8'hC0)
    ) uut (
        .clk (clk), .rst (rst), .irq_line (irq),
        .req_valid (v0), .req_write (wr), .req_addr (addr),
        .rsp_valid (rv0), .rsp_data (rd0),
        .ntf_valid (nv0), .ntf_ready (nr0), .ntf_src (ns0)
    );

    esb_source_bank #(
        .NUM_SRC (N), .SHIFT (12), .STORE_EOI (1'b0), .LEVEL_MASK (8'h00)
    ) uut1 (
        .clk (clk), .rst (rst), .irq_line (irq1),
        .req_valid (v1), .req_write (wr), .req_addr (addr[15:0]),
        .rsp_valid (rv1), .rsp_data (rd1),
        .ntf_valid (nv1), .ntf_ready (nr1), .ntf_src (ns1)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW0-1:0] tp0(int s, int off);
        return AW0'((s << 13) | off);
    endfunction

    function automatic logic [AW0-1:0] mg0(int s, int off);
        return AW0'((s << 13) | 4096 | off);
    endfunction

    function automatic logic [AW0-1:0] pg1(int s, int off);
        return AW0'((s << 12) | off);
    endfunction

    task automatic access(int inst, bit w, logic [AW0-1:0] a, output logic [63:0] q);
        @(negedge clk);
        wr   = w;
        addr = a;
        if (inst == 0) v0 = 1'b1; else v1 = 1'b1;
        @(negedge clk);
        v0 = 1'b0;
        v1 = 1'b0;
        q  = (inst == 0) ? rd0 : rd1;
    endtask

    task automatic drain();
        @(negedge clk);
        nr0 = 1'b1;
        nr1 = 1'b1;
        repeat (10) @(negedge clk);
        nr0 = 1'b0;
        nr1 = 1'b0;
    endtask

    // returns {notify, new state}; ops: 0 load EOI, 1 get, 2..5 set, 6 store EOI, 7 trigger store
    function automatic logic [2:0] model(int op, logic [1:0] s);
        case (op)
            0, 6: begin
                if (s == 2'b01) return 3'b001;
                if (s == 2'b11) return 3'b110;
                return 3'b000;
            end
            1: return {1'b0, s};
            2, 3, 4, 5: return {1'b0, 2'(op - 2)};
            default: begin
                if (s == 2'b00) return 3'b110;
                if (s == 2'b01) return 3'b001;
                return 3'b011;
            end
        endcase
    endfunction

    function automatic string tag(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            6: return "R6";
            7: return "R2";
            default: return "R5";
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] e;
        rst = 1'b1; irq = '0; irq1 = '0;
        v0 = 1'b0; v1 = 1'b0; wr = 1'b0; addr = '0; nr0 = 1'b0; nr1 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every source
        chk("R1 ntf_valid", 64'(nv0), 64'd0);
        for (int s = 0; s < N; s++) begin
            access(0, 1'b0, mg0(s, 12'h800), d);
            chk("R1 state", d, 64'd0);
        end
        chk("R4 rsp_valid after load", 64'(rv0), 64'd1);
        access(0, 1'b1, mg0(0, 12'h008), d);
        chk("R4 no rsp after store", 64'(rv0), 64'd0);

        // Sweep: edge sources x start states x operations
        for (int s = 0; s < 6; s++) begin
            for (int st = 0; st < 4; st++) begin
                for (int op = 0; op < 8; op++) begin
                    access(0, 1'b0, mg0(s, 12'hC00 | (st << 8)), d);
                    e = model(op, 2'(st));
                    case (op)
                        0: access(0, 1'b0, mg0(s, 12'h000), d);
                        1: access(0, 1'b0, mg0(s, 12'h800), d);
                        2, 3, 4, 5: access(0, 1'b0, mg0(s, 12'hC00 | ((op - 2) << 8)), d);
                        6: access(0, 1'b1, mg0(s, 12'h400), d);
                        default: access(0, 1'b1, tp0(s, 8 * s), d);
                    endcase
                    if (op < 6) chk({tag(op), " old value"}, d, 64'(st));
                    chk({tag(op), " notify"}, 64'(nv0), 64'(e[2]));
                    if (e[2]) chk({tag(op), " notify src"}, 64'(ns0), 64'(s));
                    access(0, 1'b0, mg0(s, 12'h800), d);
                    chk({tag(op), " new state"}, d, 64'(e[1:0]));
                    drain();
                end
            end
        end

        // R10 / R7: ignored accesses
        access(0, 1'b0, mg0(2, 12'hE00), d);
        access(0, 1'b0, mg0(2, 12'h100), d);
        chk("R10 undefined offset", d, '1);
        access(0, 1'b0, mg0(2, 12'h804), d);
        chk("R10 misaligned", d, '1);
        access(0, 1'b1, tp0(2, 3), d);
        access(0, 1'b0, tp0(2, 12'h800), d);
        chk("R7 load on trigger page", d, '1);
        access(0, 1'b0, mg0(2, 12'h800), d);
        chk("R10 state untouched", d, 64'd2);
        access(0, 1'b0, mg0(9, 12'h800), d);
        chk("R10 far source load", d, '1);
        access(0, 1'b1, tp0(9, 0), d);
        chk("R10 far source store", 64'(nv0), 64'd0);
        access(0, 1'b0, mg0(3, 12'hC00), d);
        access(0, 1'b1, mg0(3, 12'h000), d);
        chk("R7 store on mgmt page no trigger", 64'(nv0), 64'd0);
        access(0, 1'b0, mg0(3, 12'h800), d);
        chk("R7 mgmt store state", d, 64'd0);

        // R8: edge line
        access(0, 1'b0, mg0(0, 12'hC00), d);
        @(negedge clk); irq[0] = 1'b1;
        @(negedge clk);
        chk("R8 line notify", 64'(nv0), 64'd1);
        chk("R8 line src", 64'(ns0), 64'd0);
        drain();
        chk("R8 held line no refire", 64'(nv0), 64'd0);
        access(0, 1'b0, mg0(0, 12'h800), d);
        chk("R8 state sent", d, 64'd2);
        irq[0] = 1'b0;
        access(0, 1'b0, mg0(0, 12'h000), d);

        // R9: level source
        @(negedge clk); irq[6] = 1'b1;
        @(negedge clk);
        chk("R9 level notify", 64'(nv0), 64'd1);
        chk("R9 level src", 64'(ns0), 64'd6);
        drain();
        access(0, 1'b0, mg0(6, 12'h800), d);
        chk("R9 asserted flag", d, 64'd6);
        access(0, 1'b0, mg0(6, 12'h000), d);
        chk("R9 eoi old value", d, 64'd6);
        chk("R9 refire notify", 64'(nv0), 64'd1);
        chk("R9 refire src", 64'(ns0), 64'd6);
        access(0, 1'b0, mg0(6, 12'h800), d);
        chk("R9 refire state", d, 64'd6);
        drain();
        irq[6] = 1'b0;
        repeat (2) @(negedge clk);
        access(0, 1'b0, mg0(6, 12'h800), d);
        chk("R9 line dropped", d, 64'd2);
        access(0, 1'b0, mg0(6, 12'h000), d);
        chk("R9 no refire when low", 64'(nv0), 64'd0);
        access(0, 1'b0, mg0(6, 12'h800), d);
        chk("R9 final state", d, 64'd0);

        // R11: ordering and hold
        access(0, 1'b0, mg0(4, 12'hC00), d);
        access(0, 1'b0, mg0(1, 12'hC00), d);
        access(0, 1'b1, tp0(4, 0), d);
        chk("R11 first offer", 64'(ns0), 64'd4);
        access(0, 1'b1, tp0(1, 0), d);
        chk("R11 offer held", 64'(ns0), 64'd4);
        @(negedge clk); nr0 = 1'b1;
        @(negedge clk); nr0 = 1'b0;
        chk("R11 next offer", 64'(ns0), 64'd1);
        chk("R11 still valid", 64'(nv0), 64'd1);
        @(negedge clk); nr0 = 1'b1;
        @(negedge clk); nr0 = 1'b0;
        chk("R11 queue empty", 64'(nv0), 64'd0);

        // R6 / R7: shared page, store EOI disabled
        access(1, 1'b0, pg1(2, 12'hE00), d);
        access(1, 1'b1, pg1(2, 12'h400), d);
        access(1, 1'b0, pg1(2, 12'h800), d);
        chk("R6 store eoi disabled", d, 64'd2);
        chk("R6 no notify", 64'(nv1), 64'd0);
        access(1, 1'b1, pg1(2, 12'h010), d);
        access(1, 1'b0, pg1(2, 12'h800), d);
        chk("R7 shared page trigger", d, 64'd3);
        access(1, 1'b0, pg1(5, 12'hC00), d);
        access(1, 1'b1, pg1(5, 12'h000), d);
        chk("R7 shared notify", 64'(nv1), 64'd1);
        chk("R7 shared src", 64'(ns1), 64'd5);
        drain();
        access(1, 1'b0, pg1(2, 12'h000), d);
        chk("R3 shared eoi old", d, 64'd3);
        chk("R3 shared eoi notify", 64'(nv1), 64'd1);
        chk("R3 shared eoi src", 64'(ns1), 64'd2);
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule